// File: doc/BRIEF.md
# Debug Register Scan Target

This block is the target end of a JTAG debug path. A standard 16-state TAP controller, clocked by TCK, drives a 4-bit instruction register and a set of data registers. The debug register bank sits at the end of a two-step selection. First, a chain-select instruction loads a 4-bit chain number. Then an internal-access instruction connects the selected chain between TDI and TDO. Chain number 2 reaches the register bank. Every other chain number falls back to a one-bit bypass.

The debug chain is 38 bits long and carries three fields: a 32-bit data word, a 5-bit register address and a direction flag. On Update-DR, a set direction flag writes the data word into the addressed register. A clear flag copies the addressed register into a read holding register, so every read takes two scans: the first scan names the register, and the second scan returns its value in the data field. Registers that do not exist read as zero and ignore writes. A parallel port shows the contents of any register to the surrounding logic without going through the scan path.

Top module: `dbgscan_target`

## Requirements
- R1: While trst_n is low, the TAP is held in Test-Logic-Reset, the instruction is the identification code 0xE, the chain selection is 0, every debug register and the read holding register are 0, and tdo is 0.
- R2: Five consecutive TCK rising edges with tms high bring the TAP to Test-Logic-Reset from any state. The instruction returns to 0xE and the chain selection to 0, and the debug registers keep their contents.
- R3: The instruction register is 4 bits wide and shifts LSB first. Capture-IR loads 0b0001. The codes are 0x2 for chain select, 0xC for internal access and 0xE for identification. Every other code selects the 1-bit bypass.
- R4: With instruction 0x2, the data register is the 4-bit chain select, shifted LSB first. Capture-DR loads the current selection. The new value takes effect on Update-DR, including when the controller goes from Update-DR straight to Select-DR-Scan without passing Run-Test/Idle.
- R5: With instruction 0xC and selection 2, the data register is the 38-bit debug chain. The 32 data bits shift first (LSB first), then the 5 address bits (LSB first), and the direction bit is the last bit shifted before Update-DR. With instruction 0xC and any other selection, the data register is a 1-bit bypass that captures 0.
- R6: On Update-DR of the debug chain, a direction bit of 1 writes the data field to the addressed register. A direction bit of 0 copies the addressed register into the read holding register. The next Capture-DR loads the read holding register into the data field and zeros into the address and direction positions, so the value leaves on tdo LSB first during the first 32 shifts.
- R7: The register map has three kinds of entry. Address 0 is the control register: its low 6 bits can be written and its upper bits read 0. Address 1 is the read-only status register: bit 0 follows input dbg_ack, bit 4 follows input alt_isa, and its other bits read 0. Addresses 8 to 11 are 32-bit read/write general registers.
- R8: Reads of unimplemented addresses (2 to 7 and 12 to 31) return 0. Writes to those addresses, and writes to the status register, change no register.
- R9: tdo changes only on the falling edge of TCK. In Shift-IR and Shift-DR it shows the bit at the output end of the active shift register; in every other state it is 0.
- R10: With instruction 0xE, the data register captures the 32-bit ID_VALUE parameter and shifts it out LSB first. With instruction 0xF, the data register is a 1-bit bypass that captures 0.
- R11: par_data shows, combinationally, the value that the register map of R7 and R8 gives for address par_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| dbg_ack | input | 1 | Debug acknowledge flag shown in status bit 0 |
| alt_isa | input | 1 | Compact-instruction-state entry flag shown in status bit 4 |
| par_addr | input | ADDR_W | Address for the parallel view |
| par_data | output | DATA_W | Register contents at par_addr |

## Verification
The debug chain is tried with four kinds of stimulus. Directed writes and reads to every register class (control, status, general, unimplemented) separate correct masking from address-decode errors. A seeded random mix of reads and writes to addresses 0 to 15 is checked against a bench register model and exposes errors in field order and bit order. Some scans end through the direct Update-DR to Select-DR path and others through Run-Test/Idle, which shows whether the update is tied to the right state. Bypass patterns, identification reads and a TMS-held reset set apart the instruction decode and the chain-select decode, and show that registers survive a controller reset but not trst_n.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHIFT_DR,
        ST_EXIT1_DR,
        ST_PAUSE_DR,
        ST_EXIT2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHIFT_IR,
        ST_EXIT1_IR,
        ST_PAUSE_IR,
        ST_EXIT2_IR,
        ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDCODE,
        DR_SELECT,
        DR_DEBUG
    } dr_kind_e;

    localparam int IR_W  = 4;
    localparam int SEL_W = 4;

    localparam logic [IR_W-1:0] OP_CHAIN_SEL = 4'h2;
    localparam logic [IR_W-1:0] OP_INTERNAL  = 4'hC;
    localparam logic [IR_W-1:0] OP_IDCODE    = 4'hE;
    localparam logic [IR_W-1:0] OP_BYPASS    = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE   = 4'b0001;

    localparam logic [SEL_W-1:0] DBG_CHAIN = 4'd2;

endpackage

// File: rtl/dbgscan_tap_ctrl.sv
module dbgscan_tap_ctrl
    import dbgscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    tap_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   state_d = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   state_d = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: state_d = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: state_d = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: state_d = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: state_d = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   state_d = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   state_d = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: state_d = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: state_d = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: state_d = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: state_d = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
            default:     state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    assign state_o = state_q;

    // Run length of consecutive high tms samples, saturating at five.
    logic [2:0] tms_run_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)               tms_run_q <= 3'd0;
        else if (!tms)             tms_run_q <= 3'd0;
        else if (tms_run_q != 3'd5) tms_run_q <= tms_run_q + 3'd1;
    end

    assert_five_tms_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run_q == 3'd5) |-> (state_q == ST_RESET));

    assert_reset_exit_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET && !tms) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dbgscan_regbank.sv
module dbgscan_regbank #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int CTRL_W    = 6,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1,
    parameter int ACK_BIT   = 0,
    parameter int ALT_BIT   = 4,
    parameter int GP_BASE   = 8,
    parameter int NUM_GP    = 4
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] par_addr,
    output logic [DATA_W-1:0] par_data,
    input  logic              dbg_ack,
    input  logic              alt_isa
);

    localparam int GP_LAST = GP_BASE + NUM_GP - 1;

    typedef struct packed {
        logic [CTRL_W-1:0]              ctrl;
        logic [NUM_GP-1:0][DATA_W-1:0]  gp;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic is_writable(input logic [ADDR_W-1:0] a);
        return (int'(a) == CTRL_ADDR) || (int'(a) >= GP_BASE && int'(a) <= GP_LAST);
    endfunction

    function automatic logic [DATA_W-1:0] read_at(input logic [ADDR_W-1:0] a,
                                                  input bank_t b,
                                                  input logic ack,
                                                  input logic alt);
        logic [DATA_W-1:0] v;
        v = '0;
        if (int'(a) == CTRL_ADDR) begin
            v[CTRL_W-1:0] = b.ctrl;
        end else if (int'(a) == STAT_ADDR) begin
            v[ACK_BIT] = ack;
            v[ALT_BIT] = alt;
        end else begin
            for (int i = 0; i < NUM_GP; i++) begin
                if (int'(a) == GP_BASE + i) v = b.gp[i];
            end
        end
        return v;
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (int'(wr_addr) == CTRL_ADDR) bank_d.ctrl = wr_data[CTRL_W-1:0];
            for (int i = 0; i < NUM_GP; i++) begin
                if (int'(wr_addr) == GP_BASE + i) bank_d.gp[i] = wr_data;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign rd_data  = read_at(rd_addr,  bank_q, dbg_ack, alt_isa);
    assign par_data = read_at(par_addr, bank_q, dbg_ack, alt_isa);

    assert_nowrite_stable_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (wr_en && !is_writable(wr_addr)) |=> $stable(bank_q));

    assert_ctrl_write_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (wr_en && int'(wr_addr) == CTRL_ADDR) |=> (bank_q.ctrl == $past(wr_data[CTRL_W-1:0])));

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_chk
        assert_gp_write_R6: assert property (@(posedge tck) disable iff (!trst_n)
            (wr_en && int'(wr_addr) == GP_BASE + g) |=> (bank_q.gp[g] == $past(wr_data)));
    end

endmodule

// File: rtl/dbgscan_target.sv
module dbgscan_target
    import dbgscan_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              ADDR_W   = 5,
    parameter int              CTRL_W   = 6,
    parameter int              GP_BASE  = 8,
    parameter int              NUM_GP   = 4,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h3A51_C0DB
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    input  logic              dbg_ack,
    input  logic              alt_isa,
    input  logic [ADDR_W-1:0] par_addr,
    output logic [DATA_W-1:0] par_data
);

    localparam int CHAIN_W = DATA_W + ADDR_W + 1;
    localparam int RW_POS  = CHAIN_W - 1;

    typedef struct packed {
        logic [IR_W-1:0]    ir;
        logic [IR_W-1:0]    ir_sh;
        logic [SEL_W-1:0]   sel;
        logic [CHAIN_W-1:0] dr_sh;
        logic [DATA_W-1:0]  rd_latch;
    } scan_t;

    scan_t      s_d, s_q;
    tap_state_e state;
    dr_kind_e   kind;
    logic       wr_en;
    logic [DATA_W-1:0] rd_data;
    logic       tdo_d, tdo_q;

    dbgscan_tap_ctrl u_tap (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    dbgscan_regbank #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .CTRL_W  (CTRL_W),
        .GP_BASE (GP_BASE),
        .NUM_GP  (NUM_GP)
    ) u_bank (
        .tck      (tck),
        .trst_n   (trst_n),
        .wr_en    (wr_en),
        .wr_addr  (s_q.dr_sh[DATA_W +: ADDR_W]),
        .wr_data  (s_q.dr_sh[DATA_W-1:0]),
        .rd_addr  (s_q.dr_sh[DATA_W +: ADDR_W]),
        .rd_data  (rd_data),
        .par_addr (par_addr),
        .par_data (par_data),
        .dbg_ack  (dbg_ack),
        .alt_isa  (alt_isa)
    );

    // Which data register sits between tdi and tdo.
    always_comb begin
        case (s_q.ir)
            OP_CHAIN_SEL: kind = DR_SELECT;
            OP_INTERNAL:  kind = (s_q.sel == DBG_CHAIN) ? DR_DEBUG : DR_BYPASS;
            OP_IDCODE:    kind = DR_IDCODE;
            default:      kind = DR_BYPASS;
        endcase
    end

    // One shared shifter; the entry point of tdi depends on the active length.
    function automatic logic [CHAIN_W-1:0] shift_one(input dr_kind_e k,
                                                     input logic [CHAIN_W-1:0] v,
                                                     input logic b);
        logic [CHAIN_W-1:0] r;
        r = v >> 1;
        case (k)
            DR_BYPASS: r[0]         = b;
            DR_IDCODE: r[DATA_W-1]  = b;
            DR_SELECT: r[SEL_W-1]   = b;
            default:   r[RW_POS]    = b;
        endcase
        return r;
    endfunction

    always_comb begin
        s_d   = s_q;
        wr_en = 1'b0;
        case (state)
            ST_RESET: begin
                s_d.ir  = OP_IDCODE;
                s_d.sel = '0;
            end
            ST_CAP_IR:   s_d.ir_sh = IR_CAPTURE;
            ST_SHIFT_IR: s_d.ir_sh = {tdi, s_q.ir_sh[IR_W-1:1]};
            ST_UPD_IR:   s_d.ir    = s_q.ir_sh;
            ST_CAP_DR: begin
                case (kind)
                    DR_IDCODE: s_d.dr_sh = CHAIN_W'(ID_VALUE);
                    DR_SELECT: s_d.dr_sh = CHAIN_W'(s_q.sel);
                    DR_DEBUG:  s_d.dr_sh = CHAIN_W'(s_q.rd_latch);
                    default:   s_d.dr_sh = '0;
                endcase
            end
            ST_SHIFT_DR: s_d.dr_sh = shift_one(kind, s_q.dr_sh, tdi);
            ST_UPD_DR: begin
                if (kind == DR_SELECT) begin
                    s_d.sel = s_q.dr_sh[SEL_W-1:0];
                end else if (kind == DR_DEBUG) begin
                    if (s_q.dr_sh[RW_POS]) wr_en = 1'b1;
                    else                   s_d.rd_latch = rd_data;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            s_q       <= '0;
            s_q.ir    <= OP_IDCODE;
        end else begin
            s_q <= s_d;
        end
    end

    // Output stage, retimed to the falling edge.
    always_comb begin
        case (state)
            ST_SHIFT_IR: tdo_d = s_q.ir_sh[0];
            ST_SHIFT_DR: tdo_d = s_q.dr_sh[0];
            default:     tdo_d = 1'b0;
        endcase
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) tdo_q <= 1'b0;
        else         tdo_q <= tdo_d;
    end

    assign tdo = tdo_q;

    assert_tdo_quiet_R9: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_SHIFT_DR || state == ST_SHIFT_IR) |-> (tdo == 1'b0));

    assert_sel_cleared_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (s_q.sel == '0 && s_q.ir == OP_IDCODE));

    assert_sel_update_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_DR && kind == DR_SELECT) |=> (s_q.sel == $past(s_q.dr_sh[SEL_W-1:0])));

    assert_read_latch_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_DR && kind == DR_DEBUG && !s_q.dr_sh[RW_POS])
        |=> (s_q.rd_latch == $past(rd_data)));

    assert_no_write_outside_update_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_DR) |-> !wr_en);

endmodule

// File: tb/dbgscan_target_test.sv
module dbgscan_target_test;

    localparam logic [31:0] ID_VAL = 32'h3A51_C0DB;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        dbg_ack = 1'b0;
    logic        alt_isa = 1'b0;
    logic [4:0]  par_addr = 5'd0;
    logic [31:0] par_data;
    logic        tdo;

    always #10 tck = ~tck;

    dbgscan_target #(.ID_VALUE(ID_VAL)) uut (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .tdi      (tdi),
        .tdo      (tdo),
        .dbg_ack  (dbg_ack),
        .alt_isa  (alt_isa),
        .par_addr (par_addr),
        .par_data (par_data)
    );

    int  n_checks = 0;
    int  n_fail = 0;
    int  edge_moves = 0;
    bit  at_sel = 1'b0;
    bit  done = 1'b0;
    logic [31:0] ctrl_m = '0;
    logic [31:0] gp_m [4];

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reg(input logic [4:0] a);
        if (a == 5'd0) return ctrl_m;
        if (a == 5'd1) return {27'd0, alt_isa, 3'd0, dbg_ack};
        if (a >= 5'd8 && a <= 5'd11) return gp_m[int'(a) - 8];
        return 32'd0;
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [31:0] d);
        if (a == 5'd0) ctrl_m = d & 32'h3F;
        else if (a >= 5'd8 && a <= 5'd11) gp_m[int'(a) - 8] = d;
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        #2;
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
        if (tdo !== o) edge_moves++;
    endtask

    task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                        input bit direct, output logic [63:0] dout);
        logic o;
        dout = '0;
        if (!at_sel) tick(1'b1, 1'b0, o);
        if (is_ir)   tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o);
            dout[i] = o;
        end
        tick(1'b1, 1'b0, o);
        if (direct) begin
            tick(1'b1, 1'b0, o);
            at_sel = 1'b1;
        end else begin
            tick(1'b0, 1'b0, o);
            at_sel = 1'b0;
        end
    endtask

    task automatic set_ir(input logic [3:0] op, input bit direct, output logic [3:0] cap);
        logic [63:0] dout;
        scan(1'b1, 4, {60'd0, op}, direct, dout);
        cap = dout[3:0];
    endtask

    task automatic dbg_write(input logic [4:0] a, input logic [31:0] d, input bit direct);
        logic [63:0] dout;
        scan(1'b0, 38, {26'd0, 1'b1, a, d}, direct, dout);
        model_write(a, d);
    endtask

    task automatic dbg_read(input logic [4:0] a, input bit direct, output logic [63:0] v);
        logic [63:0] dout;
        scan(1'b0, 38, {26'd0, 1'b0, a, 32'd0}, direct, dout);
        scan(1'b0, 38, {26'd0, 1'b0, a, 32'd0}, 1'b0, dout);
        v = dout;
    endtask

    task automatic select_chain(input logic [3:0] ch, output logic [3:0] prev);
        logic [3:0]  cap;
        logic [63:0] dout;
        set_ir(4'h2, 1'b0, cap);
        scan(1'b0, 4, {60'd0, ch}, 1'b1, dout);
        prev = dout[3:0];
        set_ir(4'hC, 1'b0, cap);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic        o;
        logic [3:0]  cap;
        logic [3:0]  prev;
        logic [63:0] dout;
        logic [63:0] v;
        int unsigned seed_init;

        seed_init = $urandom(32'd90125);
        for (int i = 0; i < 4; i++) gp_m[i] = '0;

        // R1: reset values while trst_n is low
        repeat (3) @(posedge tck);
        #3;
        check("R1", "tdo in reset", {63'd0, tdo}, 64'd0);
        par_addr = 5'd8; #1;
        check("R1", "gp8 in reset", {32'd0, par_data}, 64'd0);
        @(negedge tck);
        trst_n = 1'b1;
        tick(1'b0, 1'b0, o);
        at_sel = 1'b0;

        // R10 and R1: identification is the default instruction
        scan(1'b0, 32, 64'd0, 1'b0, dout);
        check("R10", "idcode after reset", dout, {32'd0, ID_VAL});

        // R3: Capture-IR pattern
        set_ir(4'h2, 1'b0, cap);
        check("R3", "ir capture", {60'd0, cap}, 64'd1);
        // R4: select chain 2 via direct update to select path
        scan(1'b0, 4, 64'd2, 1'b1, dout);
        check("R4", "select capture before load", dout, 64'd0);
        scan(1'b0, 4, 64'd2, 1'b1, dout);
        check("R4", "select capture after load", dout, 64'd2);
        set_ir(4'hC, 1'b0, cap);

        // R6 and R11: general register write and readback
        dbg_write(5'd8, 32'hA5C3_0F96, 1'b1);
        par_addr = 5'd8; #1;
        check("R11", "parallel view of gp8", {32'd0, par_data}, 64'hA5C3_0F96);
        dbg_read(5'd8, 1'b0, v);
        check("R6", "read gp8 data field", {32'd0, v[31:0]}, 64'hA5C3_0F96);
        check("R6", "read capture upper field zero", {58'd0, v[37:32]}, 64'd0);

        // R7: control register masking
        dbg_write(5'd0, 32'hFFFF_FFFF, 1'b0);
        dbg_read(5'd0, 1'b1, v);
        check("R7", "control masked", {32'd0, v[31:0]}, 64'h3F);

        // R7 and R8: status register
        dbg_ack = 1'b1; alt_isa = 1'b1;
        dbg_read(5'd1, 1'b0, v);
        check("R7", "status both flags", {32'd0, v[31:0]}, 64'h11);
        dbg_write(5'd1, 32'hFFFF_FFFF, 1'b0);
        par_addr = 5'd1; #1;
        check("R8", "status write ignored", {32'd0, par_data}, 64'h11);
        dbg_ack = 1'b0;
        dbg_read(5'd1, 1'b0, v);
        check("R7", "status ack low", {32'd0, v[31:0]}, 64'h10);
        alt_isa = 1'b0;

        // R8: unimplemented addresses
        dbg_write(5'd5, 32'h1234_5678, 1'b0);
        dbg_read(5'd5, 1'b0, v);
        check("R8", "unimpl read 5", {32'd0, v[31:0]}, 64'd0);
        dbg_write(5'd31, 32'hDEAD_BEEF, 1'b1);
        dbg_read(5'd12, 1'b0, v);
        check("R8", "unimpl read 12", {32'd0, v[31:0]}, 64'd0);
        for (int a = 0; a < 16; a++) begin
            par_addr = 5'(a); #1;
            check("R8", "map unchanged after unimpl writes", {32'd0, par_data}, {32'd0, exp_reg(5'(a))});
        end

        // R5 and R6: seeded random mix
        for (int k = 0; k < 40; k++) begin
            logic [4:0]  a;
            logic [31:0] d;
            bit          dir;
            a = 5'($urandom_range(0, 15));
            d = $urandom();
            dir = 1'($urandom_range(0, 1));
            dbg_ack = 1'($urandom_range(0, 1));
            alt_isa = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) begin
                dbg_write(a, d, dir);
            end else begin
                dbg_read(a, dir, v);
                check("R6", "random read", {32'd0, v[31:0]}, {32'd0, exp_reg(a)});
            end
        end

        // R5: internal access with other chain is a bypass
        select_chain(4'd0, prev);
        check("R4", "select readback 2", {60'd0, prev}, 64'd2);
        scan(1'b0, 8, 64'hB6, 1'b0, dout);
        check("R5", "chain 0 bypass", dout, 64'h6C);
        // R10: bypass instruction
        set_ir(4'hF, 1'b0, cap);
        scan(1'b0, 8, 64'h59, 1'b0, dout);
        check("R10", "bypass instruction", dout, 64'hB2);
        // R3: unlisted code also bypass
        set_ir(4'h7, 1'b1, cap);
        scan(1'b0, 8, 64'hC3, 1'b0, dout);
        check("R3", "unlisted code bypass", dout, 64'h86);

        // R9: tdo quiet in idle
        tick(1'b0, 1'b1, o);
        tick(1'b0, 1'b1, o);
        check("R9", "tdo in idle", {63'd0, o}, 64'd0);

        // R2: five tms high reset keeps registers
        select_chain(4'd2, prev);
        dbg_write(5'd9, 32'h0BAD_F00D, 1'b0);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        at_sel = 1'b0;
        scan(1'b0, 32, 64'd0, 1'b0, dout);
        check("R2", "idcode after tms reset", dout, {32'd0, ID_VAL});
        set_ir(4'h2, 1'b0, cap);
        scan(1'b0, 4, 64'd0, 1'b0, dout);
        check("R2", "select cleared", dout, 64'd0);
        par_addr = 5'd9; #1;
        check("R2", "gp9 survives tms reset", {32'd0, par_data}, 64'h0BAD_F00D);

        check("R9", "tdo moved at rising edge", edge_moves, 64'd0);

        // R1: trst_n clears registers
        @(negedge tck);
        trst_n = 1'b0;
        #2;
        check("R1", "gp9 cleared by trst", {32'd0, par_data}, 64'd0);
        check("R1", "tdo low in trst", {63'd0, tdo}, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule